// File: doc/BRIEF.md
# Two-Level SMI Status Collector

This block turns eight external system-management request lines and three internal trigger events into latched status bits. It drives one active-high SMI line to the processor and a top-level summary bit that a higher-level status register can show. The internal events are a write to the command port, a write of 1 to the sleep control bit and a write of 1 to the throttle control bit. Each external request line passes through a two-flop synchronizer. Only a rising edge on an enabled line sets its status bit.

Software reaches the block through a small word-wide register port with four addresses. The external word holds the eight source enables, a status field that clears when it is read, a read-only copy of the same status that clears nothing, and a reserved top byte. A separate word holds the two internal enables and the three internal status bits, which software clears by writing 1 to them. A third address receives the sleep and throttle control writes, and a fourth is the command port.

Top module: `smi_status_collector`

## Requirements
- R1: After reset the external word (address 0) reads 0, the internal word (address 2) reads 32'h0000_0003 (both internal enables set, no status), and smi_o and top_sum_o are 0.
- R2: A rising edge on an external line whose enable bit (address 0, bit i for line i) is 0 sets no status bit and does not raise smi_o.
- R3: A rising edge on enabled external line i sets status bit 16+i and its copy at bit 8+i of address 0. Both are visible three clock edges after the input rises. smi_o is then 1.
- R4: A read of address 0 with byte lane 2 enabled (reg_be_i[2]=1) clears bits [23:16], bits [15:8] and top_sum_o at that clock edge. smi_o is 0 from that edge on if no other status bit is set.
- R5: A read of address 0 with reg_be_i[2]=0 returns the status and leaves it, top_sum_o and smi_o unchanged.
- R6: top_sum_o is 1 whenever any external status bit is set.
- R7: Bits [31:24] of address 0 read as 0, and writes to them are ignored.
- R8: Any write to address 3 sets the command status bit (address 2, bit 10) and raises smi_o, whatever the enables hold.
- R9: A write of 1 to address 1 bit 0 sets the sleep status bit (address 2, bit 8), and a write of 1 to address 1 bit 1 sets the throttle status bit (address 2, bit 9). Each is set only when its enable is 1: bit 0 of address 2 for sleep, bit 1 for throttle.
- R10: An external event that lands on the same clock edge as a clearing read keeps its status bit set. top_sum_o also stays set.
- R11: An external line held high sets its status bit once. The bit does not set again after it has been cleared.
- R12: Writing 1 to a bit in [10:8] of address 2 clears that internal status bit. smi_o falls when no status bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | 8 | External SMI request lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address (0 external, 1 control, 2 internal, 3 command) |
| reg_be_i | input | 4 | Read byte lanes; lane 2 selects the clearing status view |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| smi_o | output | 1 | SMI request to the processor |
| top_sum_o | output | 1 | Top-level summary of the external status bits |

## Verification
A status bit stuck or lost inside the block shows on smi_o and top_sum_o at the next clock edge. It shows in the two status fields of address 0 on the next read. An edge detector that mistakes a held level for a new event shows as a status bit that comes back a few cycles after a clearing read. A clear that beats a new event shows as a missing bit in the first non-destructive read after the clear. A clearing view wired to the wrong byte lane shows as status that survives a clearing read, or as status that vanishes after a read that should clear nothing.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int EXT_W     = 8;
  localparam int INT_W     = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int SYNC_STGS = 2;
  localparam int MIR_LO    = 8;
  localparam int ST_LO     = 16;
  localparam int CLR_LANE  = 2;
  localparam int INT_ST_LO = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_EXT  = 2'd0,
    A_CTRL = 2'd1,
    A_INT  = 2'd2,
    A_CMD  = 2'd3
  } reg_addr_e;

  // internal status bit positions
  localparam int I_SLP = 0;
  localparam int I_THR = 1;
  localparam int I_CMD = 2;
endpackage

// File: rtl/smi_sync_edge.sv
module smi_sync_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] pipe_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= async_i;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[k] <= '0;
      else         pipe_q[k] <= pipe_q[k-1];
    end
  end

  // last flop holds previous synchronized level
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  assert_held_level_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/smi_ext_bank.sv
module smi_ext_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] st_o,
  output logic         sum_o
);
  logic [W-1:0] en_q, st_q, set_w;
  logic         sum_q;

  assign set_w = rise_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      st_q  <= '0;
      sum_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      // new events win over a coincident clear
      st_q  <= (st_q & {W{~clr_i}}) | set_w;
      sum_q <= (sum_q & ~clr_i) | (|set_w);
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign sum_o = sum_q;

  assert_gated_by_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));
  assert_clear_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_w == '0) |=> (st_q == '0 && !sum_q));
  assert_summary_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|st_q) |-> sum_q);
  assert_event_survives_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_w != '0) |=> ((st_q & $past(set_w)) == $past(set_w) && sum_q));
endmodule

// File: rtl/smi_int_bank.sv
module smi_int_bank
  import smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slp_wr_i,
  input  logic             thr_wr_i,
  input  logic             cmd_wr_i,
  input  logic             en_wr_i,
  input  logic [1:0]       en_wdata_i,
  input  logic [INT_W-1:0] clr_mask_i,
  output logic [1:0]       en_o,
  output logic [INT_W-1:0] st_o
);
  logic [1:0]       en_q;
  logic [INT_W-1:0] st_q, set_w;

  always_comb begin
    set_w        = '0;
    set_w[I_SLP] = slp_wr_i & en_q[0];
    set_w[I_THR] = thr_wr_i & en_q[1];
    set_w[I_CMD] = cmd_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 2'b11;
      st_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      st_q <= (st_q & ~clr_mask_i) | set_w;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;

  assert_cmd_sets_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> st_q[I_CMD]);
  assert_slp_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slp_wr_i && !en_q[0] && !st_q[I_SLP]) |=> !st_q[I_SLP]);
  assert_w1c_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask_i[I_THR] && !thr_wr_i) |=> !st_q[I_THR]);
endmodule

// File: rtl/smi_status_collector.sv
module smi_status_collector
  import smi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EXT_W-1:0]  ext_req_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              smi_o,
  output logic              top_sum_o
);
  logic [EXT_W-1:0] rise_w, ext_en_w, ext_st_w;
  logic [1:0]       int_en_w;
  logic [INT_W-1:0] int_st_w, int_clr_w;
  logic             ext_clr_w, ext_sum_w;
  logic             wr_ext, wr_ctrl, wr_int, wr_cmd;

  assign wr_ext  = reg_wr_i && reg_addr_i == A_EXT;
  assign wr_ctrl = reg_wr_i && reg_addr_i == A_CTRL;
  assign wr_int  = reg_wr_i && reg_addr_i == A_INT;
  assign wr_cmd  = reg_wr_i && reg_addr_i == A_CMD;

  assign ext_clr_w = reg_rd_i && reg_addr_i == A_EXT && reg_be_i[CLR_LANE];
  assign int_clr_w = wr_int ? reg_wdata_i[INT_ST_LO +: INT_W] : '0;

  smi_sync_edge #(.W(EXT_W), .STAGES(SYNC_STGS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_req_i),
    .rise_o  (rise_w)
  );

  smi_ext_bank #(.W(EXT_W)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise_w),
    .en_wr_i    (wr_ext),
    .en_wdata_i (reg_wdata_i[EXT_W-1:0]),
    .clr_i      (ext_clr_w),
    .en_o       (ext_en_w),
    .st_o       (ext_st_w),
    .sum_o      (ext_sum_w)
  );

  smi_int_bank u_int (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slp_wr_i   (wr_ctrl && reg_wdata_i[0]),
    .thr_wr_i   (wr_ctrl && reg_wdata_i[1]),
    .cmd_wr_i   (wr_cmd),
    .en_wr_i    (wr_int),
    .en_wdata_i (reg_wdata_i[1:0]),
    .clr_mask_i (int_clr_w),
    .en_o       (int_en_w),
    .st_o       (int_st_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_EXT: begin
        reg_rdata_o[EXT_W-1:0]           = ext_en_w;
        reg_rdata_o[MIR_LO +: EXT_W]     = ext_st_w;
        reg_rdata_o[ST_LO +: EXT_W]      = ext_st_w;
      end
      A_INT: begin
        reg_rdata_o[1:0]                 = int_en_w;
        reg_rdata_o[INT_ST_LO +: INT_W]  = int_st_w;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign smi_o     = (|(ext_st_w & ext_en_w)) | (|int_st_w);
  assign top_sum_o = ext_sum_w;

  assert_cmd_raises_smi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> smi_o);
  assert_peek_keeps_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_EXT && !reg_be_i[CLR_LANE] && !reg_wr_i) |=>
      ((ext_st_w & $past(ext_st_w)) == $past(ext_st_w) && (top_sum_o || !$past(top_sum_o))));
  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:ST_LO+EXT_W] == '0);
endmodule

// File: tb/smi_status_collector_tb_top.sv
`timescale 1ns/1ps
module smi_status_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_req = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        smi, top_sum;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  smi_status_collector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .smi_o(smi), .top_sum_o(top_sum)
  );

  // {enable, pulse pattern, expected status}
  localparam logic [23:0] VEC [5] = '{
    {8'hFF, 8'hA5, 8'hA5},
    {8'h0F, 8'hFF, 8'h0F},
    {8'h00, 8'hFF, 8'h00},
    {8'hF0, 8'h3C, 8'h30},
    {8'h81, 8'h81, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [3:0] lanes, output logic [31:0] d);
    addr = a; be = lanes; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; be = '0;
  endtask

  task automatic pulse(input logic [7:0] p);
    ext_req = p;
    step(1);
    ext_req = '0;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    bus_rd(2'd0, 4'h0, d); chk("R1 ext word", d, 32'h0);
    bus_rd(2'd2, 4'h0, d); chk("R1 int word", d, 32'h3);
    chk("R1 smi", {31'b0, smi}, 32'h0);
    chk("R1 top", {31'b0, top_sum}, 32'h0);

    // R7 reserved byte
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd0, 4'h0, d); chk("R7 reserved ignored", d, 32'h0000_00FF);

    // table: R2 R3 R4
    for (int i = 0; i < 5; i++) begin
      bus_wr(2'd0, {24'h0, VEC[i][23:16]});
      pulse(VEC[i][15:8]);
      bus_rd(2'd0, 4'h0, d);
      chk("R3/R2 status field", {24'h0, d[23:16]}, {24'h0, VEC[i][7:0]});
      chk("R3 mirror field", {24'h0, d[15:8]}, {24'h0, VEC[i][7:0]});
      bus_rd(2'd0, 4'h4, d);
      bus_rd(2'd0, 4'h0, d);
      chk("R4 cleared", {16'h0, d[23:8]}, 32'h0);
    end

    // R3 R6 R5 R4 directed
    bus_wr(2'd0, 32'hFF);
    pulse(8'h04);
    chk("R3 smi high", {31'b0, smi}, 32'h1);
    chk("R6 summary", {31'b0, top_sum}, 32'h1);
    bus_rd(2'd0, 4'hB, d);
    chk("R5 peek value", d, 32'h0004_04FF);
    bus_rd(2'd0, 4'h3, d);
    chk("R5 peek keeps", d, 32'h0004_04FF);
    chk("R5 smi kept", {31'b0, smi}, 32'h1);
    chk("R5 top kept", {31'b0, top_sum}, 32'h1);
    bus_rd(2'd0, 4'h4, d);
    chk("R4 clear read value", d, 32'h0004_04FF);
    chk("R4 smi low", {31'b0, smi}, 32'h0);
    chk("R4 top low", {31'b0, top_sum}, 32'h0);

    // R11 held level
    ext_req = 8'h02;
    step(3);
    chk("R11 first set", {31'b0, smi}, 32'h1);
    bus_rd(2'd0, 4'h4, d);
    step(5);
    bus_rd(2'd0, 4'h0, d);
    chk("R11 no re-set", {24'h0, d[23:16]}, 32'h0);
    chk("R11 smi stays low", {31'b0, smi}, 32'h0);
    ext_req = '0;
    step(3);

    // R10 event coincident with clearing read
    pulse(8'h01);
    ext_req = 8'h08;
    step(1);
    ext_req = '0;
    step(1);
    bus_rd(2'd0, 4'h4, d);
    bus_rd(2'd0, 4'h0, d);
    chk("R10 new event kept", {24'h0, d[23:16]}, 32'h08);
    chk("R10 top kept", {31'b0, top_sum}, 32'h1);
    bus_rd(2'd0, 4'h4, d);

    // R8 command port, with all enables off
    bus_wr(2'd0, 32'h0);
    bus_wr(2'd2, 32'h0);
    bus_wr(2'd3, 32'h1234_5678);
    chk("R8 smi", {31'b0, smi}, 32'h1);
    bus_rd(2'd2, 4'h0, d); chk("R8 status", d, 32'h0000_0400);

    // R12 write-1-to-clear
    bus_wr(2'd2, 32'h0000_0403);
    chk("R12 smi low", {31'b0, smi}, 32'h0);
    bus_rd(2'd2, 4'h0, d); chk("R12 cleared", d, 32'h0000_0003);

    // R9 sleep/throttle
    bus_wr(2'd1, 32'h1);
    bus_rd(2'd2, 4'h0, d); chk("R9 sleep set", d, 32'h0000_0103);
    bus_wr(2'd1, 32'h2);
    bus_rd(2'd2, 4'h0, d); chk("R9 throttle set", d, 32'h0000_0303);
    chk("R9 smi", {31'b0, smi}, 32'h1);
    bus_wr(2'd2, 32'h0000_0300);
    bus_wr(2'd1, 32'h3);
    bus_rd(2'd2, 4'h0, d); chk("R9 disabled no set", d, 32'h0);
    chk("R9 disabled smi", {31'b0, smi}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule